// File: doc/BRIEF.md
# Buffered Host Read Port with Wait States

This block is the host-facing side of a peripheral whose word storage is shared with an internal engine. A host processor starts a transfer by pulling its chip-select and strobe low. Neither of them needs to be aligned to the block clock. The block waits until the engine has let go of the storage. It then drives a transfer-enable low and holds the transfer's control and address from then on. After a fixed number of wait states it drives a ready handshake low with the read word on the data bus. Enable and ready both return high once the host lifts its strobe.

The storage is a word memory plus a small register file. The engine writes both through its own request/grant port. Which level of the host direction input means "read" is set by a polarity input. A request that first shows up in the clock-low half period just before a sampling edge counts as a setup miss. That case costs exactly one extra cycle before the address is frozen.

Top module: `hba_host_access`

## Requirements
- R1: During and straight after synchronous active-high reset, `xfer_en_n` and `host_rdy_n` are 1, `host_rdata` is 0 and `eng_gnt` is 0.
- R2: Chip-select and strobe each pass through a two-stage synchroniser. Count the first rising edge that samples both low as edge 1. `xfer_en_n` falls on edge 3, provided `eng_gnt` is low at that edge. After that, raising `host_cs_n` has no effect on the transfer.
- R3: With `eng_req` high and no transfer running, `eng_gnt` rises on the next rising edge. While `eng_gnt` is high, a host request waits. `eng_gnt` clears on the first rising edge after `eng_req` falls, and `xfer_en_n` falls on the edge after that.
- R4: `eng_gnt` stays 0 for the whole time `xfer_en_n` is low. If `eng_req` is held, `eng_gnt` rises on the rising edge after the one that raises `xfer_en_n`.
- R5: `host_mem` (1 = memory, 0 = register file) and `host_dir` are taken live until the first falling clock edge after `xfer_en_n` falls, and are frozen from that edge on.
- R6: `host_addr` is taken live until the first rising edge after `xfer_en_n` falls, and is frozen from that edge on.
- R7: If the request is first sampled on a rising edge but was not yet present at the preceding falling edge, the address freeze moves one rising edge later. The delay from `xfer_en_n` falling to `host_rdy_n` falling grows by one cycle.
- R8: `host_rdy_n` falls READY_DLY (default 2) rising edges after the address freeze. With no setup miss this is READY_DLY+1 cycles after `xfer_en_n` falls.
- R9: On a read, `host_rdata` carries memory word `host_addr` (64 words by default) or register word `host_addr` (8 words by default). An address beyond the selected space reads 0. Register word i holds 0x5A00+i after reset. `host_rdata` is 0 whenever `host_rdy_n` is 1.
- R10: A transfer is a read when `host_dir` equals `dir_pol`. A transfer that is not a read still completes the enable/ready handshake, with `host_rdata` held at 0.
- R11: On the third rising edge after `host_stb_n` goes high, `xfer_en_n` and `host_rdy_n` both return to 1 and `host_rdata` returns to 0.
- R12: On a rising edge where `eng_gnt` and `eng_we` are both 1, `eng_wdata` is stored at `eng_addr` in the memory (`eng_mem`=1) or in the register file (`eng_mem`=0). A write to an address beyond that space is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip-select, active low, asynchronous |
| host_stb_n | input | 1 | Host strobe, active low, asynchronous |
| host_mem | input | 1 | 1 selects memory, 0 selects register file |
| host_dir | input | 1 | Transfer direction level |
| dir_pol | input | 1 | Level of `host_dir` that means read |
| host_addr | input | 16 | Host word address |
| eng_req | input | 1 | Internal engine storage request |
| eng_we | input | 1 | Engine write enable |
| eng_mem | input | 1 | Engine target: 1 memory, 0 register file |
| eng_addr | input | 16 | Engine word address |
| eng_wdata | input | 16 | Engine write data |
| xfer_en_n | output | 1 | Transfer enable, active low |
| host_rdy_n | output | 1 | Ready handshake, active low |
| host_rdata | output | 16 | Read data, zero outside the ready window |
| eng_gnt | output | 1 | Engine holds the storage |

## Verification
A stuck or skipped control state shows up at the pins within a cycle or two. A missing slip cycle or a wrong wait count moves the falling edge of `host_rdy_n` by whole cycles. An early or late freeze of address or control picks the wrong word, because the bench changes those inputs on the very edges around the capture points. An ownership mix-up shows as `eng_gnt` high during a transfer, or as the enable falling while the engine still holds the storage. Stale read data shows as a nonzero bus outside the ready window. The bench's reference model predicts every output on every clock, so any of these faults is reported in the cycle it first appears.

// File: rtl/hba_pkg.sv
package hba_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } hba_state_e;

    typedef struct packed {
        logic is_mem;
        logic dir;
    } hba_ctrl_t;

    localparam logic [15:0] REG_SEED_BASE = 16'h5A00;

    function automatic logic dir_is_read(input logic dir, input logic pol);
        return dir == pol;
    endfunction

    function automatic logic [15:0] reg_seed(input int idx);
        return REG_SEED_BASE | 16'(idx & 255);
    endfunction

endpackage

// File: rtl/hba_sync.sv
module hba_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hba_store.sv
module hba_store import hba_pkg::*; #(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int MEM_AW = 6,
    parameter int REG_AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_mem,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_mem,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    localparam int MEM_WORDS = 1 << MEM_AW;
    localparam int REG_WORDS = 1 << REG_AW;

    logic [DW-1:0] mem [MEM_WORDS];
    logic [DW-1:0] reg_view [REG_WORDS];

    logic wr_mem_ok, wr_reg_ok, rd_mem_ok, rd_reg_ok;
    assign wr_mem_ok = wr_en &&  wr_mem && (wr_addr < AW'(MEM_WORDS));
    assign wr_reg_ok = wr_en && !wr_mem && (wr_addr < AW'(REG_WORDS));
    assign rd_mem_ok = rd_addr < AW'(MEM_WORDS);
    assign rd_reg_ok = rd_addr < AW'(REG_WORDS);

    always_ff @(posedge clk) begin
        if (wr_mem_ok) mem[wr_addr[MEM_AW-1:0]] <= wr_data;
    end

    for (genvar r = 0; r < REG_WORDS; r++) begin : g_reg
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) word_q <= DW'(reg_seed(r));
            else if (wr_reg_ok && wr_addr[REG_AW-1:0] == REG_AW'(r)) word_q <= wr_data;
        end
        assign reg_view[r] = word_q;
    end

    always_comb begin
        if (rd_mem) rd_word = rd_mem_ok ? mem[rd_addr[MEM_AW-1:0]] : '0;
        else        rd_word = rd_reg_ok ? reg_view[rd_addr[REG_AW-1:0]] : '0;
    end
endmodule

// File: rtl/hba_seq.sv
module hba_seq import hba_pkg::*; #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int READY_DLY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raw_req,
    input  logic          req_s,
    input  logic          stb_s,
    input  logic          late_s,
    input  logic          host_mem,
    input  logic          host_dir,
    input  logic          dir_pol,
    input  logic [AW-1:0] host_addr,
    input  logic          eng_req,
    input  logic [DW-1:0] rd_word,
    output logic          early_seen,
    output logic          rd_mem,
    output logic [AW-1:0] rd_addr,
    output logic          xfer_en_n,
    output logic          host_rdy_n,
    output logic [DW-1:0] host_rdata,
    output logic          eng_gnt
);
    localparam int CW = $clog2(READY_DLY + 1);

    hba_state_e    state;
    hba_ctrl_t     ctrl_q, ctrl_eff;
    logic          ctrl_held;
    logic [AW-1:0] addr_q;
    logic          addr_held;
    logic          slip_q, slip_used;
    logic [CW-1:0] wait_cnt;
    logic          is_read;

    // Falling-edge side: early request sample and control freeze.
    always_ff @(negedge clk) begin
        if (rst) begin
            early_seen <= 1'b0;
            ctrl_q     <= '0;
            ctrl_held  <= 1'b0;
        end else begin
            early_seen <= raw_req;
            if (state == ST_IDLE) begin
                ctrl_held <= 1'b0;
            end else if (!ctrl_held) begin
                ctrl_q    <= '{is_mem: host_mem, dir: host_dir};
                ctrl_held <= 1'b1;
            end
        end
    end

    assign ctrl_eff = ctrl_held ? ctrl_q : '{is_mem: host_mem, dir: host_dir};
    assign rd_mem   = ctrl_eff.is_mem;
    assign rd_addr  = addr_held ? addr_q : host_addr;
    assign is_read  = dir_is_read(ctrl_eff.dir, dir_pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            xfer_en_n  <= 1'b1;
            host_rdy_n <= 1'b1;
            host_rdata <= '0;
            eng_gnt    <= 1'b0;
            addr_q     <= '0;
            addr_held  <= 1'b0;
            slip_q     <= 1'b0;
            slip_used  <= 1'b0;
            wait_cnt   <= '0;
        end else if (state == ST_IDLE) begin
            addr_held <= 1'b0;
            slip_used <= 1'b0;
            if (req_s && !eng_gnt) begin
                state     <= ST_ADDR;
                xfer_en_n <= 1'b0;
                eng_gnt   <= 1'b0;
                slip_q    <= late_s;
            end else begin
                eng_gnt <= eng_req;
            end
        end else if (!stb_s) begin
            state      <= ST_IDLE;
            xfer_en_n  <= 1'b1;
            host_rdy_n <= 1'b1;
            host_rdata <= '0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (slip_q && !slip_used) begin
                        slip_used <= 1'b1;
                    end else begin
                        addr_q    <= host_addr;
                        addr_held <= 1'b1;
                        wait_cnt  <= CW'(1);
                        state     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt == CW'(READY_DLY)) begin
                        host_rdy_n <= 1'b0;
                        host_rdata <= is_read ? rd_word : '0;
                        state      <= ST_DONE;
                    end else begin
                        wait_cnt <= wait_cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: ready only inside the enable window
    a_r8_ready_inside_enable: assert property (@(posedge clk) disable iff (rst)
        !host_rdy_n |-> !xfer_en_n);
    // R4: never two owners of the storage
    a_r4_single_owner: assert property (@(posedge clk) disable iff (rst)
        eng_gnt |-> xfer_en_n);
    // R2: enable falls only on a synchronised request with the engine idle
    a_r2_start_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_en_n) |-> ($past(req_s) && !$past(eng_gnt)));
    // R9: bus quiet outside the ready window
    a_r9_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        host_rdy_n |-> (host_rdata == '0));
    // R6: frozen address does not move
    a_r6_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (addr_held && $past(addr_held)) |-> $stable(rd_addr));
    // R5: frozen control does not move
    a_r5_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
        (ctrl_held && $past(ctrl_held)) |-> $stable(ctrl_q));
    // R11: strobe release ends the transfer on the next edge
    a_r11_release: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !stb_s) |=> (xfer_en_n && host_rdy_n));
endmodule

// File: rtl/hba_host_access.sv
module hba_host_access #(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int MEM_AW      = 6,
    parameter int REG_AW      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int READY_DLY   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_cs_n,
    input  logic          host_stb_n,
    input  logic          host_mem,
    input  logic          host_dir,
    input  logic          dir_pol,
    input  logic [AW-1:0] host_addr,
    input  logic          eng_req,
    input  logic          eng_we,
    input  logic          eng_mem,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    output logic          xfer_en_n,
    output logic          host_rdy_n,
    output logic [DW-1:0] host_rdata,
    output logic          eng_gnt
);
    logic          raw_req, early_seen;
    logic [2:0]    sync_d, sync_q;
    logic          cs_s, stb_s, late_s, req_s;
    logic          rd_mem;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_word;

    assign raw_req = !host_cs_n && !host_stb_n;
    assign sync_d  = {raw_req && !early_seen, !host_stb_n, !host_cs_n};
    assign {late_s, stb_s, cs_s} = sync_q;
    assign req_s   = cs_s && stb_s;

    hba_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_d),
        .q   (sync_q)
    );

    hba_store #(.AW(AW), .DW(DW), .MEM_AW(MEM_AW), .REG_AW(REG_AW)) i_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (eng_gnt && eng_we),
        .wr_mem  (eng_mem),
        .wr_addr (eng_addr),
        .wr_data (eng_wdata),
        .rd_mem  (rd_mem),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    hba_seq #(.AW(AW), .DW(DW), .READY_DLY(READY_DLY)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .raw_req    (raw_req),
        .req_s      (req_s),
        .stb_s      (stb_s),
        .late_s     (late_s),
        .host_mem   (host_mem),
        .host_dir   (host_dir),
        .dir_pol    (dir_pol),
        .host_addr  (host_addr),
        .eng_req    (eng_req),
        .rd_word    (rd_word),
        .early_seen (early_seen),
        .rd_mem     (rd_mem),
        .rd_addr    (rd_addr),
        .xfer_en_n  (xfer_en_n),
        .host_rdy_n (host_rdy_n),
        .host_rdata (host_rdata),
        .eng_gnt    (eng_gnt)
    );
endmodule

// File: tb/test_hba_host_access.sv
`timescale 1ns/1ps
module test_hba_host_access;
    localparam int RDY  = 2;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b1, host_stb_n = 1'b1, host_mem = 1'b1, host_dir = 1'b1, dir_pol = 1'b1;
    logic [15:0] host_addr = '0;
    logic        eng_req = 1'b0, eng_we = 1'b0, eng_mem = 1'b1;
    logic [15:0] eng_addr = '0, eng_wdata = '0;
    logic        xfer_en_n, host_rdy_n, eng_gnt;
    logic [15:0] host_rdata;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    logic [15:0] ref_mem [64];
    logic [15:0] ref_reg [8];

    always #10 clk = ~clk;

    hba_host_access i_hba_host_access (
        .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_stb_n(host_stb_n),
        .host_mem(host_mem), .host_dir(host_dir), .dir_pol(dir_pol), .host_addr(host_addr),
        .eng_req(eng_req), .eng_we(eng_we), .eng_mem(eng_mem), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .xfer_en_n(xfer_en_n), .host_rdy_n(host_rdy_n),
        .host_rdata(host_rdata), .eng_gnt(eng_gnt)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string tag, input logic e_en, input logic e_rdy,
                           input logic [15:0] e_dat, input logic e_gnt);
        chk(tag, "xfer_en_n", 32'(xfer_en_n), 32'(e_en));
        chk(tag, "host_rdy_n", 32'(host_rdy_n), 32'(e_rdy));
        chk(tag, "host_rdata", 32'(host_rdata), 32'(e_dat));
        chk(tag, "eng_gnt", 32'(eng_gnt), 32'(e_gnt));
    endtask

    function automatic logic [15:0] exp_word(input logic sp, input logic dir, input logic [15:0] a);
        if (dir != dir_pol) return 16'h0;
        if (sp) return (a < 16'd64) ? ref_mem[a[5:0]] : 16'h0;
        return (a < 16'd8) ? ref_reg[a[2:0]] : 16'h0;
    endfunction

    task automatic eng_write(input logic sp, input logic [15:0] wa, input logic [15:0] wd);
        @(posedge clk); #7; eng_req = 1'b1; eng_we = 1'b0;
        @(posedge clk); #5; chk("R3", "eng_gnt rise", 32'(eng_gnt), 32'd1);
        #2; eng_we = 1'b1; eng_mem = sp; eng_addr = wa; eng_wdata = wd;
        @(posedge clk); #7; eng_req = 1'b0; eng_we = 1'b0;
        @(posedge clk); #5; chk("R3", "eng_gnt clear", 32'(eng_gnt), 32'd0);
        if (sp && wa < 16'd64) ref_mem[wa[5:0]] = wd;
        if (!sp && wa < 16'd8) ref_reg[wa[2:0]] = wd;
    endtask

    // Cycle-by-cycle expected outputs for one host read transfer.
    task automatic host_read(input string tag, input logic sp, input logic dir, input logic [15:0] a,
                             input bit late, input int hold, input int chg_i, input int chg_off,
                             input logic sp2, input logic [15:0] a2, input bit sel_early,
                             input int eng_drop_i, input bit eng_mid);
        int s, lt, cap, rdy_i, rel;
        logic eff_sp;
        logic [15:0] eff_a, dval;
        logic e_en, e_rdy, e_gnt;
        s     = (eng_drop_i > 0 && eng_drop_i + 2 > SYNC + 1) ? eng_drop_i + 2 : SYNC + 1;
        lt    = (late && s == SYNC + 1) ? 1 : 0;
        cap   = s + 1 + lt;
        rdy_i = cap + RDY;
        rel   = rdy_i + hold;
        eff_sp = (chg_i > 0 && (chg_i < s || (chg_i == s && chg_off < 10))) ? sp2 : sp;
        eff_a  = (chg_i > 0 && chg_i < cap) ? a2 : a;
        dval   = exp_word(eff_sp, dir, eff_a);
        @(posedge clk);
        if (late) #14; else #2;
        host_cs_n = 1'b0; host_stb_n = 1'b0; host_mem = sp; host_dir = dir; host_addr = a;
        for (int i = 1; i <= rel + 4; i++) begin
            @(posedge clk);
            #2;
            if (chg_i == i && chg_off == 2) begin host_mem = sp2; host_addr = a2; end
            #3;
            e_en  = !(i >= s && i < rel + 3);
            e_rdy = !(i >= rdy_i && i < rel + 3);
            if (i < s) e_gnt = (eng_drop_i > 0 && i <= eng_drop_i);
            else if (i >= rel + 4) e_gnt = eng_req;
            else e_gnt = 1'b0;
            chk_all(tag, e_en, e_rdy, e_rdy ? 16'h0 : dval, e_gnt);
            #2;
            if (i == rel) begin host_stb_n = 1'b1; host_cs_n = 1'b1; end
            if (sel_early && i == s) host_cs_n = 1'b1;
            if (eng_drop_i > 0 && i == eng_drop_i) eng_req = 1'b0;
            if (eng_mid && i == s) eng_req = 1'b1;
            #5;
            if (chg_i == i && chg_off == 12) begin host_mem = sp2; host_addr = a2; end
        end
    endtask

    initial begin
        for (int k = 0; k < 64; k++) ref_mem[k] = 16'h0;
        for (int k = 0; k < 8; k++) ref_reg[k] = 16'h5A00 + 16'(k);
        repeat (3) @(posedge clk);
        #5; chk_all("R1", 1'b1, 1'b1, 16'h0, 1'b0);
        #2; rst = 1'b0;
        @(posedge clk); #5; chk_all("R1", 1'b1, 1'b1, 16'h0, 1'b0);

        // R12: engine fills memory and one register; out-of-range writes dropped
        for (int k = 0; k < 64; k++) eng_write(1'b1, 16'(k), 16'h1000 + 16'(k * 3));
        eng_write(1'b1, 16'd5,  16'h1234);
        eng_write(1'b1, 16'd63, 16'hBEEF);
        eng_write(1'b1, 16'd10, 16'h0F0F);
        eng_write(1'b0, 16'd2,  16'h7777);
        eng_write(1'b0, 16'd8,  16'hDEAD);   // beyond register file: dropped
        eng_write(1'b1, 16'd64, 16'hDEAD);   // beyond memory: dropped

        // R2: basic memory read
        host_read("R2", 1'b1, 1'b1, 16'd5, 0, 1, 0, 2, 1'b1, 16'd0, 0, 0, 0);
        // R9: register seed, engine-written register, out-of-range reads
        host_read("R9", 1'b0, 1'b1, 16'd3, 0, 1, 0, 2, 1'b0, 16'd0, 0, 0, 0);
        host_read("R12", 1'b0, 1'b1, 16'd0, 0, 0, 0, 2, 1'b0, 16'd0, 0, 0, 0);
        host_read("R12", 1'b0, 1'b1, 16'd2, 0, 0, 0, 2, 1'b0, 16'd0, 0, 0, 0);
        host_read("R9", 1'b1, 1'b1, 16'd64, 0, 0, 0, 2, 1'b1, 16'd0, 0, 0, 0);
        host_read("R9", 1'b0, 1'b1, 16'h8000, 0, 0, 0, 2, 1'b0, 16'd0, 0, 0, 0);
        // R5: control change after the falling edge is ignored, address still live
        host_read("R5", 1'b1, 1'b1, 16'd5, 0, 1, 3, 12, 1'b0, 16'd10, 0, 0, 0);
        // R5: control change before the falling edge is taken
        host_read("R5", 1'b1, 1'b1, 16'd5, 0, 1, 3, 2, 1'b0, 16'd2, 0, 0, 0);
        // R6: change after the address freeze is ignored
        host_read("R6", 1'b1, 1'b1, 16'd5, 0, 1, 4, 2, 1'b0, 16'd10, 0, 0, 0);
        // R7: setup miss, slip cycle lets a later address change through
        host_read("R7", 1'b1, 1'b1, 16'd5, 1, 1, 4, 2, 1'b1, 16'd63, 0, 0, 0);
        host_read("R7", 1'b1, 1'b1, 16'd10, 1, 2, 0, 2, 1'b1, 16'd0, 0, 0, 0);
        // R8: long hold keeps ready and data stable
        host_read("R8", 1'b1, 1'b1, 16'd20, 0, 5, 0, 2, 1'b1, 16'd0, 0, 0, 0);
        // R10: inverted polarity read, then a non-read transfer
        dir_pol = 1'b0;
        host_read("R10", 1'b1, 1'b0, 16'd63, 0, 1, 0, 2, 1'b1, 16'd0, 0, 0, 0);
        dir_pol = 1'b1;
        host_read("R10", 1'b1, 1'b0, 16'd63, 0, 1, 0, 2, 1'b1, 16'd0, 0, 0, 0);
        // R2: chip-select released early, transfer completes
        host_read("R2", 1'b1, 1'b1, 16'd7, 0, 1, 0, 2, 1'b1, 16'd0, 1, 0, 0);
        // R11: release right as ready falls
        host_read("R11", 1'b1, 1'b1, 16'd11, 0, 0, 0, 2, 1'b1, 16'd0, 0, 0, 0);
        // R3: engine holds the storage, host waits
        @(posedge clk); #7; eng_req = 1'b1;
        @(posedge clk); #5; chk("R3", "eng_gnt before host", 32'(eng_gnt), 32'd1);
        host_read("R3", 1'b1, 1'b1, 16'd5, 0, 1, 0, 2, 1'b1, 16'd0, 0, 6, 0);
        // R4: engine asks during a transfer, granted after it ends
        host_read("R4", 1'b1, 1'b1, 16'd10, 0, 1, 0, 2, 1'b1, 16'd0, 0, 0, 1);
        #2; eng_req = 1'b0;
        @(posedge clk); #5; chk("R4", "eng_gnt drop", 32'(eng_gnt), 32'd0);
        chk_all("R11", 1'b1, 1'b1, 16'h0, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule